// File: doc/BRIEF.md
# I2C Master SCL Clock Generator with Line Synchronization

This block produces the serial clock for an I2C master from a faster source clock. A programmable divisor sets the bit period. The block divides that period into a low half and a high half. It drives the shared clock line through an open-drain style pull-low request, so the actual line level is the wired-AND of every device on the bus. The block watches the real line level through a synchronizer and adapts to it.

The block never starts its high count until the line is really high. A slave that holds the line low therefore stretches the bit. When another device pulls the line low during the block's high phase, the block gives up the rest of that high phase and starts a full low count of its own. Several masters thus settle on a common clock whose low time comes from the slowest low phase.

A bit engine uses the three single-cycle strobes: start of low phase, start of high phase, and a mid-high sample point. When the block is disabled (slave operation or idle), it never pulls the line and emits no strobes.

Top module: `scl_clkgen`

## Requirements
- R1: For an effective divisor E, each low phase asserts `scl_pull` for exactly floor(E/2) consecutive source clocks. For an odd E this is (E-1)/2.
- R2: With no interference on the line, `high_start` and the following `low_start` are exactly floor(E/2) cycles apart.
- R3: The effective divisor E equals `divisor`, raised to 4 when `multi_master`=0 and to 8 when `multi_master`=1 if it is below that floor.
- R4: On a free line, `high_start` pulses exactly 3 cycles after `scl_pull` drops. These are two synchronizer stages plus the phase register.
- R5: The high phase does not begin while the line is held low by another device. `high_start` pulses 3 cycles after the line is released, and `scl_pull` still lasts only floor(E/2) cycles.
- R6: If the line goes low during the high phase, `low_start` pulses 3 cycles later. A full low phase of floor(E/2) cycles follows.
- R7: `sample_pt` pulses once per undisturbed high phase, floor(floor(E/2)/2) cycles after `high_start`. At most one of the three strobes is high in any cycle.
- R8: While `master_en`=0, `scl_pull`, `low_start`, `high_start` and `sample_pt` stay 0. Clearing `master_en` releases `scl_pull` after one clock edge.
- R9: After reset all outputs are 0. `low_start` pulses in the first cycle of each low phase, while `scl_pull` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | 1 = act as clock master; 0 = idle, line untouched |
| divisor | input | DIV_W (16) | Source clocks per bit |
| multi_master | input | 1 | Selects the higher divisor floor for shared-bus use |
| scl_in | input | 1 | Sampled level of the shared clock line |
| scl_pull | output | 1 | 1 = pull the clock line low |
| low_start | output | 1 | Pulse in the first cycle of a low phase |
| high_start | output | 1 | Pulse in the first cycle of a high phase |
| sample_pt | output | 1 | Pulse at the middle of a high phase |

## Verification
The bench builds the block with its defaults: a 16-bit divisor, two synchronizer stages, and floors of 4 and 8. It sweeps every divisor from 0 to 20 in both modes, so every clamped value and every odd/even split near the floors is measured. Two large odd and even divisors are also measured. The shared line is modeled as a wired-AND with an external pull. This lets the bench stretch a low phase well past the block's own count and cut a high phase short partway through, and it checks the restart and release timing that these cases produce.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_WAIT = 2'd2,
        PH_HIGH = 2'd3
    } phase_e;

endpackage

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = line_in;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], line_in};
        end
    endgenerate

    // an idle bus floats high, so reset to the released level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign line_s = sh_q[STAGES-1];
endmodule

// File: rtl/scl_half_calc.sv
module scl_half_calc #(
    parameter int DIV_W      = 16,
    parameter int MIN_SINGLE = 4,
    parameter int MIN_MULTI  = 8
) (
    input  logic [DIV_W-1:0] divisor,
    input  logic             multi_master,
    output logic [DIV_W-1:0] half_len,
    output logic [DIV_W-1:0] mid_pos
);
    localparam logic [DIV_W-1:0] FLOOR_S = DIV_W'(MIN_SINGLE);
    localparam logic [DIV_W-1:0] FLOOR_M = DIV_W'(MIN_MULTI);

    logic [DIV_W-1:0] floor_v;
    logic [DIV_W-1:0] eff;

    always_comb begin
        floor_v = multi_master ? FLOOR_M : FLOOR_S;
        eff     = (divisor < floor_v) ? floor_v : divisor;
        // even E: E/2 each half; odd E: (E-1)/2 each half -> both are E>>1
        half_len = {1'b0, eff[DIV_W-1:1]};
        mid_pos  = {1'b0, half_len[DIV_W-1:1]};
    end
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_gen_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             line_s,
    input  logic [DIV_W-1:0] half_len,
    input  logic [DIV_W-1:0] mid_pos,
    output logic             pull,
    output logic             strb_low,
    output logic             strb_high,
    output logic             strb_samp
);
    typedef struct packed {
        phase_e           ph;
        logic [DIV_W-1:0] cnt;
        logic             s_low;
        logic             s_high;
        logic             s_samp;
    } fsm_t;

    localparam fsm_t FSM_RST = '{ph: PH_IDLE, cnt: '0, s_low: 1'b0, s_high: 1'b0, s_samp: 1'b0};

    fsm_t st_d, st_q;
    logic [DIV_W-1:0] last_cnt;
    logic [DIV_W-1:0] cnt_inc;

    always_comb begin
        last_cnt     = half_len - 1'b1;
        cnt_inc      = st_q.cnt + 1'b1;
        st_d         = st_q;
        st_d.s_low   = 1'b0;
        st_d.s_high  = 1'b0;
        st_d.s_samp  = 1'b0;
        unique case (st_q.ph)
            PH_IDLE: begin
                st_d.ph    = PH_LOW;
                st_d.cnt   = '0;
                st_d.s_low = 1'b1;
            end
            PH_LOW: begin
                if (st_q.cnt >= last_cnt) begin
                    st_d.ph  = PH_WAIT;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = cnt_inc;
                end
            end
            PH_WAIT: begin
                // high count may only begin once the line really is high
                if (line_s) begin
                    st_d.ph     = PH_HIGH;
                    st_d.cnt    = '0;
                    st_d.s_high = 1'b1;
                end
            end
            PH_HIGH: begin
                if (!line_s || st_q.cnt >= last_cnt) begin
                    st_d.ph    = PH_LOW;
                    st_d.cnt   = '0;
                    st_d.s_low = 1'b1;
                end else begin
                    st_d.cnt    = cnt_inc;
                    st_d.s_samp = (cnt_inc == mid_pos);
                end
            end
            default: st_d = FSM_RST;
        endcase
        if (!en) st_d = FSM_RST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FSM_RST;
        else        st_q <= st_d;
    end

    assign pull      = (st_q.ph == PH_LOW);
    assign strb_low  = st_q.s_low;
    assign strb_high = st_q.s_high;
    assign strb_samp = st_q.s_samp;

    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_q.s_low, st_q.s_high, st_q.s_samp}));

    assert_quiet_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!pull && !strb_low && !strb_high && !strb_samp));

    assert_high_after_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.s_high) |-> $past(line_s));

    assert_restart_on_line_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_HIGH && !line_s && en) |=> (pull && strb_low));

    assert_low_strobe_pulls_R9: assert property (@(posedge clk) disable iff (!rst_n)
        strb_low |-> pull);
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen #(
    parameter int DIV_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_SINGLE  = 4,
    parameter int MIN_MULTI   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             master_en,
    input  logic [DIV_W-1:0] divisor,
    input  logic             multi_master,
    input  logic             scl_in,
    output logic             scl_pull,
    output logic             low_start,
    output logic             high_start,
    output logic             sample_pt
);
    localparam logic [DIV_W-1:0] HALF_FLOOR_S = DIV_W'(MIN_SINGLE / 2);
    localparam logic [DIV_W-1:0] HALF_FLOOR_M = DIV_W'(MIN_MULTI / 2);

    logic             line_s;
    logic [DIV_W-1:0] half_len;
    logic [DIV_W-1:0] mid_pos;

    scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (scl_in),
        .line_s  (line_s)
    );

    scl_half_calc #(
        .DIV_W      (DIV_W),
        .MIN_SINGLE (MIN_SINGLE),
        .MIN_MULTI  (MIN_MULTI)
    ) u_half (
        .divisor      (divisor),
        .multi_master (multi_master),
        .half_len     (half_len),
        .mid_pos      (mid_pos)
    );

    scl_phase_fsm #(.DIV_W(DIV_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (master_en),
        .line_s    (line_s),
        .half_len  (half_len),
        .mid_pos   (mid_pos),
        .pull      (scl_pull),
        .strb_low  (low_start),
        .strb_high (high_start),
        .strb_samp (sample_pt)
    );

    assert_clamp_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        half_len >= (multi_master ? HALF_FLOOR_M : HALF_FLOOR_S));
endmodule

// File: tb/scl_clkgen_tb.sv
module scl_clkgen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          master_en = 1'b0;
    logic [DW-1:0] divisor = '0;
    logic          multi_master = 1'b0;
    logic          ext_low = 1'b0;
    logic          scl_in;
    logic          scl_pull, low_start, high_start, sample_pt;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // wired-AND bus line
    assign scl_in = ~(scl_pull | ext_low);

    scl_clkgen u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .master_en    (master_en),
        .divisor      (divisor),
        .multi_master (multi_master),
        .scl_in       (scl_in),
        .scl_pull     (scl_pull),
        .low_start    (low_start),
        .high_start   (high_start),
        .sample_pt    (sample_pt)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // enable from idle and measure one full bit period
    task automatic measure(input int div, input bit mm);
        int eff, half, lc, wc, hc, so;
        master_en = 1'b0;
        repeat (3) @(negedge clk);
        divisor = DW'(div);
        multi_master = mm;
        master_en = 1'b1;
        eff  = (div < (mm ? 8 : 4)) ? (mm ? 8 : 4) : div;
        half = eff / 2;
        while (!low_start) @(negedge clk);
        chk(scl_pull == 1'b1, "R9 pull with low_start", int'(scl_pull), 1);
        lc = 0;
        while (scl_pull) begin lc++; @(negedge clk); end
        chk(lc == half, $sformatf("R1 R3 low width div=%0d mm=%0d", div, mm), lc, half);
        wc = 0;
        while (!high_start) begin wc++; @(negedge clk); end
        chk(wc == 3, "R4 release to high_start", wc, 3);
        hc = 0; so = -1;
        while (!low_start) begin
            if (sample_pt) so = hc;
            hc++;
            @(negedge clk);
        end
        chk(hc == half, $sformatf("R2 R3 high width div=%0d mm=%0d", div, mm), hc, half);
        chk(so == half / 2, "R7 sample offset", so, half / 2);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int d, pc, viol;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({scl_pull, low_start, high_start, sample_pt} == 4'b0, "R9 reset outputs",
            int'({scl_pull, low_start, high_start, sample_pt}), 0);

        for (int mm = 0; mm < 2; mm++)
            for (int dv = 0; dv <= 20; dv++)
                measure(dv, mm[0]);
        measure(301, 1'b1);
        measure(300, 1'b0);

        // R5: external device stretches the low phase
        master_en = 1'b0;
        repeat (3) @(negedge clk);
        divisor = 16'd10; multi_master = 1'b0; master_en = 1'b1;
        while (!low_start) @(negedge clk);
        ext_low = 1'b1;
        d = 0; pc = 0;
        while (!high_start) begin
            if (scl_pull) pc++;
            @(negedge clk);
            d++;
            if (d == 12) ext_low = 1'b0;
        end
        chk(d == 15, "R5 stretched high_start delay", d, 15);
        chk(pc == 5, "R5 own pull width while stretched", pc, 5);

        // R6: external low cuts the high phase short
        divisor = 16'd20;
        while (!high_start) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        ext_low = 1'b1;
        d = 2;
        while (!low_start) begin @(negedge clk); d++; end
        ext_low = 1'b0;
        chk(d == 5, "R6 restart delay", d, 5);
        pc = 0;
        while (scl_pull) begin pc++; @(negedge clk); end
        chk(pc == 10, "R6 full low after restart", pc, 10);

        // R8: disable mid-low, then stay quiet
        while (!low_start) @(negedge clk);
        master_en = 1'b0;
        @(negedge clk);
        chk(scl_pull == 1'b0, "R8 release after disable", int'(scl_pull), 0);
        viol = 0;
        for (int i = 0; i < 40; i++) begin
            if (scl_pull || low_start || high_start || sample_pt) viol++;
            @(negedge clk);
        end
        chk(viol == 0, "R8 quiet while disabled", viol, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule